// File: doc/BRIEF.md
# Early-Interrupt Conversion Timer for a Shared ADC Core

This block models the timing of one conversion on a shared successive-approximation ADC core. Time is counted in core clock periods, and each period is marked by a one-cycle enable tick on the system clock. There is no analog path: a down-counter stands in for the sampling and comparator steps. It places two events in time. The data-ready point is the end of the conversion. The early point falls a programmable number of core clocks before data ready.

A conversion starts on an accepted start request. At that moment the block latches the resolution code, the 3-bit lead select and the early-interrupt enable. The early flag and the ready flag are set at their events and stay set until the next accepted start. A single-cycle interrupt pulse is raised at one of the two events, chosen by the latched enable. Some lead values cannot be used with the short resolutions. For those the block raises a registered configuration error and clamps the lead to the largest value that is legal for that resolution.

Top module: `adc_eirq_timer`

## Requirements
- R1: After synchronous reset, `busy`, `early_flag`, `ready_flag`, `irq` and `cfg_err` are all 0.
- R2: A conversion lasts 8, 10, 12 or 14 ticks for resolution codes 00, 01, 10 and 11. This is 6, 8, 10 or 12 bits plus 2 ticks of overhead. `ready_flag` rises on the last of these ticks, counted from the accepted start, and `busy` falls at the same edge.
- R3: A lead select value k (0 to 7) makes `early_flag` rise on the tick that leaves k+1 ticks before data ready.
- R4: When the latched early enable is 1, `irq` pulses for exactly one cycle at the edge where `early_flag` rises, and it does not pulse at data ready.
- R5: When the latched early enable is 0, `irq` pulses for exactly one cycle at the edge where `ready_flag` rises, and it does not pulse at the early point.
- R6: `cfg_err` is registered one cycle after the inputs. It is 1 exactly when the resolution is 00 with select 4 to 7, or when the resolution is 01 with select 6 or 7.
- R7: An illegal combination uses a lead of 4 ticks at resolution 00 and 6 ticks at resolution 01.
- R8: `early_flag` and `ready_flag` remain set after the conversion ends and clear at the edge that accepts the next start.
- R9: A start request while `busy` is 1 is ignored, and the running conversion keeps its timing.
- R10: Resolution, lead select and early enable are sampled only when a start is accepted. Changes during a conversion have no effect on it.
- R11: The conversion advances only on cycles with `tick` high, so timing in ticks does not depend on how far apart the ticks are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle marker of a core clock period |
| start | input | 1 | Conversion start request |
| res_sel | input | 2 | Resolution code (00=6, 01=8, 10=10, 11=12 bits) |
| lead_sel | input | 3 | Early lead select k, lead = k+1 ticks |
| early_en | input | 1 | 1: interrupt at the early point, 0: at data ready |
| busy | output | 1 | Conversion in progress |
| early_flag | output | 1 | Early point reached (sticky until next start) |
| ready_flag | output | 1 | Data ready (sticky until next start) |
| irq | output | 1 | Single-cycle channel interrupt pulse |
| cfg_err | output | 1 | Current resolution/select combination is illegal |

## Verification
The hardest cases to reach from the ports are those where inputs move while a conversion runs: a start request held high through the cycle in which data ready lands, and the configuration inputs swapped mid-conversion. The directed task for these keeps `start` high and inverts every configuration input on each cycle of the conversion. It then checks that the event tick numbers and the interrupt source still match the values sampled at the accepted start. The same conversion scenarios also run with ticks several system clocks apart, so that tick counting and not cycle counting is what gets checked.

// File: rtl/adc_eirq_pkg.sv
package adc_eirq_pkg;
  localparam int RES_W     = 2;
  localparam int SEL_W     = 3;
  localparam int MIN_BITS  = 6;
  localparam int BIT_STEP  = 2;
  localparam int OVERHEAD  = 2;
  localparam int MAX_LEN   = MIN_BITS + BIT_STEP * ((1 << RES_W) - 1) + OVERHEAD;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int LEAD_CAP  = 1 << SEL_W;

  function automatic int res_bits(input logic [RES_W-1:0] res);
    return MIN_BITS + BIT_STEP * int'(res);
  endfunction

  function automatic int conv_len(input logic [RES_W-1:0] res);
    return res_bits(res) + OVERHEAD;
  endfunction

  // Largest usable lead: two below the bit count, capped by the select range.
  function automatic int max_lead(input logic [RES_W-1:0] res);
    int m;
    m = res_bits(res) - 2;
    return (m > LEAD_CAP) ? LEAD_CAP : m;
  endfunction
endpackage

// File: rtl/adc_lead_decode.sv
module adc_lead_decode
  import adc_eirq_pkg::*;
(
  input  logic [RES_W-1:0] res_sel,
  input  logic [SEL_W-1:0] lead_sel,
  output logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] lead,
  output logic             illegal
);
  int want;
  int cap;

  always_comb begin
    want    = int'(lead_sel) + 1;
    cap     = max_lead(res_sel);
    illegal = (want > cap);
    lead    = illegal ? CNT_W'(cap) : CNT_W'(want);
    len     = CNT_W'(conv_len(res_sel));
  end

  // p_lead_below_len_r7: a clamped or plain lead always precedes data ready
  always_comb begin
    p_lead_below_len_r7: assert (lead < len && lead != '0);
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_eirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] len_in,
  input  logic [CNT_W-1:0] lead_in,
  output logic             busy,
  output logic             accept,
  output logic             early_hit,
  output logic             ready_hit,
  output logic             early_flag,
  output logic             ready_flag
);
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] lead_q;
  logic [CNT_W-1:0] rem_nxt;

  assign accept    = start && !busy;
  assign rem_nxt   = rem - CNT_W'(1);
  assign early_hit = busy && tick && (rem_nxt == lead_q);
  assign ready_hit = busy && tick && (rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      rem        <= '0;
      lead_q     <= '0;
      early_flag <= 1'b0;
      ready_flag <= 1'b0;
    end else if (accept) begin
      busy       <= 1'b1;
      rem        <= len_in;
      lead_q     <= lead_in;
      early_flag <= 1'b0;
      ready_flag <= 1'b0;
    end else if (busy && tick) begin
      rem <= rem_nxt;
      if (early_hit) early_flag <= 1'b1;
      if (ready_hit) begin
        ready_flag <= 1'b1;
        busy       <= 1'b0;
      end
    end
  end

  // p_early_at_lead_r3: early flag rises when exactly lead ticks remain
  p_early_at_lead_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(early_flag) |-> (rem == lead_q));

  // p_ready_ends_busy_r2: data ready and end of busy coincide
  p_ready_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_flag) |-> (!busy && early_flag));

  // p_no_restart_r9: a start while busy without a tick leaves the count alone
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick) |=> ($stable(rem) && $stable(lead_q)));

  // p_tick_gates_r11: without a tick nothing advances
  p_tick_gates_r11: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(rem));
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic early_en,
  input  logic early_hit,
  input  logic ready_hit,
  output logic irq
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (accept) en_q <= early_en;
      irq <= en_q ? early_hit : ready_hit;
    end
  end

  // p_irq_pulse_r4: the interrupt never lasts two cycles
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // p_irq_source_r5: with the late mode latched, only data ready may fire
  p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !accept && early_hit && !ready_hit) |=> !irq);
endmodule

// File: rtl/adc_eirq_timer.sv
module adc_eirq_timer
  import adc_eirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [RES_W-1:0] res_sel,
  input  logic [SEL_W-1:0] lead_sel,
  input  logic             early_en,
  output logic             busy,
  output logic             early_flag,
  output logic             ready_flag,
  output logic             irq,
  output logic             cfg_err
);
  logic [CNT_W-1:0] len_w;
  logic [CNT_W-1:0] lead_w;
  logic             illegal_w;
  logic             accept_w;
  logic             early_hit_w;
  logic             ready_hit_w;

  adc_lead_decode u_dec (
    .res_sel (res_sel),
    .lead_sel(lead_sel),
    .len     (len_w),
    .lead    (lead_w),
    .illegal (illegal_w)
  );

  adc_conv_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (start),
    .len_in    (len_w),
    .lead_in   (lead_w),
    .busy      (busy),
    .accept    (accept_w),
    .early_hit (early_hit_w),
    .ready_hit (ready_hit_w),
    .early_flag(early_flag),
    .ready_flag(ready_flag)
  );

  adc_irq_gen u_irq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept_w),
    .early_en (early_en),
    .early_hit(early_hit_w),
    .ready_hit(ready_hit_w),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= illegal_w;
  end

  // p_err_follows_r6: the error flag tracks the previous cycle's inputs
  p_err_follows_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(res_sel) == 2'b11) |-> !cfg_err);
endmodule

// File: tb/tb_adc_eirq_timer.sv
module tb_adc_eirq_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic [1:0] res_sel = '0;
  logic [2:0] lead_sel = '0;
  logic       early_en = 1'b0;
  logic       busy, early_flag, ready_flag, irq, cfg_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_eirq_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .res_sel(res_sel), .lead_sel(lead_sel), .early_en(early_en),
    .busy(busy), .early_flag(early_flag), .ready_flag(ready_flag),
    .irq(irq), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int r);
    return 8 + 2 * r;
  endfunction

  function automatic int exp_lead(input int r, input int k);
    int cap;
    cap = (r == 0) ? 4 : (r == 1) ? 6 : 8;
    return (k + 1 > cap) ? cap : k + 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", int'(busy), 0);
    chk("R1 early_flag", int'(early_flag), 0);
    chk("R1 ready_flag", int'(ready_flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
  endtask

  // One conversion; gap = system clocks per tick; disturb = hold start and
  // flip the configuration inputs during the conversion.
  task automatic run_conv(input int r, input int k, input bit en,
                          input int gap, input bit disturb, input string tag);
    int n, cyc, early_n, ready_n, irq_n, irq_cnt, len, ld;
    len = exp_len(r);
    ld  = exp_lead(r, k);
    @(negedge clk);
    res_sel = 2'(r); lead_sel = 3'(k); early_en = en; start = 1'b1; tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 flags cleared at start"}, int'(early_flag) + int'(ready_flag), 0);
    chk({tag, " R2 busy after start"}, int'(busy), 1);
    n = 0; cyc = 0; early_n = -1; ready_n = -1; irq_n = -1; irq_cnt = 0;
    while (ready_n < 0 && cyc < 400) begin
      tick = (cyc % gap == 0);
      if (disturb) begin
        start    = 1'b1;
        res_sel  = ~2'(r);
        lead_sel = ~3'(k);
        early_en = ~en;
      end
      @(negedge clk);
      if (tick) n++;
      cyc++;
      if (early_flag && early_n < 0) early_n = n;
      if (irq) begin irq_cnt++; irq_n = n; end
      if (ready_flag) ready_n = n;
    end
    start = 1'b0; tick = 1'b0;
    res_sel = 2'(r); lead_sel = 3'(k); early_en = en;
    chk({tag, " R2 R9 R10 R11 ready tick"}, ready_n, len);
    chk({tag, " R3 R7 R10 early tick"}, early_n, len - ld);
    chk({tag, " R2 busy low at ready"}, int'(busy), 0);
    chk({tag, " R4 R5 irq tick"}, irq_n, en ? len - ld : len);
    repeat (3) begin
      @(negedge clk);
      if (irq) irq_cnt++;
    end
    chk({tag, " R4 R5 single irq"}, irq_cnt, 1);
    chk({tag, " R8 flags held"}, int'(early_flag) + int'(ready_flag), 2);
  endtask

  task automatic test_err_table();
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 8; k++) begin
        int exp;
        exp = ((r == 0 && k >= 4) || (r == 1 && k >= 6)) ? 1 : 0;
        @(negedge clk);
        res_sel = 2'(r); lead_sel = 3'(k);
        @(negedge clk);
        chk($sformatf("R6 cfg_err res=%0d sel=%0d", r, k), int'(cfg_err), exp);
      end
    end
  endtask

  task automatic test_no_tick();
    @(negedge clk);
    res_sel = 2'd0; lead_sel = 3'd0; early_en = 1'b0; start = 1'b1; tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R11 no progress without ticks", int'(busy) * 4 + int'(early_flag) * 2 + int'(ready_flag), 4);
    for (int i = 0; i < 8; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    chk("R11 R2 done after 8 ticks", int'(ready_flag), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    run_conv(0, 0, 1'b0, 1, 1'b0, "r2_res0_late");
    run_conv(3, 7, 1'b1, 1, 1'b0, "r3_res3_k7_early");
    run_conv(2, 2, 1'b1, 3, 1'b0, "r11_res2_gap3");
    run_conv(1, 4, 1'b0, 2, 1'b0, "r5_res1_late");
    run_conv(0, 6, 1'b1, 1, 1'b0, "r7_res0_clamp");
    run_conv(1, 7, 1'b1, 2, 1'b0, "r7_res1_clamp");
    run_conv(2, 5, 1'b1, 1, 1'b1, "r9_r10_disturb_a");
    run_conv(1, 1, 1'b0, 2, 1'b1, "r9_r10_disturb_b");
    test_err_table();
    test_no_tick();
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule